// File: doc/BRIEF.md
# Scanline Horizontal Phase Sequencer with External Sync

This block steps one video scanline through four horizontal phases in a fixed order: blank-tail (`BT`), sync-wait (`SW`), lead-in (`LI`) and visible (`VS`), then wraps to `BT`. Software programs the length of each phase in character units of `CHAR_PIX` pixel clocks. The block runs one clock per pixel.

A companion output chip may send a horizontal sync pulse. That pulse controls the line length, and it need not match the programmed phase lengths. The sync-wait phase acts as a timeout window. A sync edge during that window ends it at once and moves the block into lead-in. A sync edge in any other phase starts a new line at blank-tail. If no sync arrives, the programmed lengths set the line period.

The block counts a blanking position from each blank-tail entry. At a programmable offset it strobes sprite-line preparation, and at a later offset it strobes background-line preparation. A sync edge that lands between the two offsets raises a sprite-drop pulse. Background preparation is not affected by that sync edge. A single-cycle line interrupt marks each entry to blank-tail.

Top module: `scanline_phase_seq`

## Requirements
- R1: The phases run in the order BT, SW, LI, VS and then back to BT, with the encoding BT=0, SW=1, LI=2, VS=3 on `phase_o`. Each phase lasts `CHAR_PIX` times its programmed length in clocks. A programmed length of 0 counts as 1 unit.
- R2: With no sync edge, SW ends when its own count expires, and the next cycle is in LI.
- R3: A sync rising edge sampled while in SW puts the block in LI on the next cycle, and LI then runs its full length.
- R4: A sync rising edge sampled in BT, LI or VS puts the block at the first cycle of BT on the next cycle, with the phase counters and the blanking position cleared.
- R5: Sync is edge-detected. A level held high for many cycles causes exactly one restart, and the phases then advance normally.
- R6: When a sync edge falls in the last cycle of a phase, the sync takes priority over the count expiry.
- R7: `line_irq_o` is high for exactly the first cycle of each BT entry, whether the entry comes from a wrap or from a restart. It stays low out of reset.
- R8: The blanking position is 0 in the first BT cycle and rises by one each clock outside VS. `spr_prep_o` is high in the cycle where the position equals `spr_ofs_i`, and `bg_prep_o` is high in the cycle where it equals `bg_ofs_i`. Neither strobe is high in VS. Both fire again on every line.
- R9: A sync edge sampled outside VS, while the position is at least `spr_ofs_i` and below `bg_ofs_i`, gives a one-cycle `spr_drop_o` on the next cycle. If that edge does not restart the line, `bg_prep_o` still fires at `bg_ofs_i`.
- R10: `active_o` is high only while the phase is VS.
- R11: While `rst_n` is low at a clock edge, the block sits at the start of BT with all counters cleared and all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | External horizontal sync level |
| len_bt_i | input | LEN_W | Blank-tail length in character units |
| len_sw_i | input | LEN_W | Sync-wait timeout length in character units |
| len_li_i | input | LEN_W | Lead-in length in character units |
| len_vs_i | input | LEN_W | Visible length in character units |
| spr_ofs_i | input | POS_W | Blanking position of the sprite preparation strobe |
| bg_ofs_i | input | POS_W | Blanking position of the background preparation strobe |
| phase_o | output | 2 | Current phase code |
| active_o | output | 1 | Visible-region flag |
| line_irq_o | output | 1 | Line interrupt pulse |
| spr_prep_o | output | 1 | Sprite-line preparation strobe |
| bg_prep_o | output | 1 | Background-line preparation strobe |
| spr_drop_o | output | 1 | Sprite line abandoned by early sync |

## Verification
The hardest case to reach is a sync edge that lands inside the narrow gap between the sprite and background offsets. Proving that background preparation still follows such an edge is harder still, because it needs an edge that does not restart the line. The bench places the background offset inside the sync-wait window and raises sync there. The edge then ends sync-wait early without restarting the line, and the bench checks that the drop pulse appears and that the background strobe still comes at its scheduled position during lead-in. Separate tests cover sync on the exact expiry cycle of a phase and a sync level held across most of a line.

// File: rtl/scan_pkg.sv
// Shared phase encoding for the scanline sequencer.
// Assumes exactly four horizontal phases, visited in encoding order.
package scan_pkg;
    typedef enum logic [1:0] {
        PH_BT = 2'd0,   // blank-tail, line start
        PH_SW = 2'd1,   // sync-wait timeout window
        PH_LI = 2'd2,   // lead-in before visible
        PH_VS = 2'd3    // visible pixels
    } phase_t;
    localparam int NUM_PH = 4;
endpackage

// File: rtl/sync_edge_det.sv
// Rising-edge detector for the external sync level.
// Assumes sync_in is already synchronous to clk. The history flop is left out
// of reset so that an edge is judged against the true prior level.
module sync_edge_det (
    input  logic clk,
    input  logic sync_in,
    output logic rise_o
);
    logic sync_q;

    // Keep last cycle's sync level.
    always_ff @(posedge clk) begin
        sync_q <= sync_in;
    end

    assign rise_o = sync_in & ~sync_q;
endmodule

// File: rtl/phase_engine.sv
// Phase state machine with per-phase character counters.
// Each phase spends max(len,1) units of CHAR_PIX clocks. A sync edge in SW
// jumps to LI; a sync edge elsewhere restarts at BT. Sync beats expiry.
// Assumes len_pk holds the lengths indexed by phase code.
module phase_engine
    import scan_pkg::*;
#(
    parameter int LEN_W    = 6,
    parameter int CHAR_PIX = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rise_i,
    input  logic [NUM_PH-1:0][LEN_W-1:0]  len_pk,
    output phase_t                        phase_o,
    output logic                          enter_bt_o,
    output logic                          irq_o
);
    localparam int SUB_W = (CHAR_PIX > 1) ? $clog2(CHAR_PIX) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CHAR_PIX - 1);

    logic [LEN_W-1:0] units [NUM_PH];
    logic [SUB_W-1:0] sub_q;
    logic [LEN_W-1:0] unit_q;
    phase_t           phase_q;
    logic             last_cyc;
    logic             restart;

    // Zero-length phases are widened to one unit.
    for (genvar g = 0; g < NUM_PH; g++) begin : g_units
        assign units[g] = (len_pk[g] == '0) ? LEN_W'(1) : len_pk[g];
    end

    assign last_cyc   = (sub_q == SUB_LAST) && (unit_q == units[phase_q] - LEN_W'(1));
    assign restart    = rise_i && (phase_q != PH_SW);
    assign enter_bt_o = restart || (!rise_i && last_cyc && phase_q == PH_VS);

    // Advance phase and counters, sync first, then expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_BT;
            sub_q   <= '0;
            unit_q  <= '0;
        end else if (rise_i) begin
            phase_q <= (phase_q == PH_SW) ? PH_LI : PH_BT;
            sub_q   <= '0;
            unit_q  <= '0;
        end else if (last_cyc) begin
            phase_q <= phase_t'(phase_q + 2'd1);
            sub_q   <= '0;
            unit_q  <= '0;
        end else if (sub_q == SUB_LAST) begin
            sub_q   <= '0;
            unit_q  <= unit_q + LEN_W'(1);
        end else begin
            sub_q   <= sub_q + SUB_W'(1);
        end
    end

    // One-cycle interrupt on every BT entry.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= enter_bt_o;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/prep_timer.sv
// Blanking position counter and preparation strobes.
// The position is cleared on BT entry, counts outside VS, and saturates.
// Assumes spr_ofs < bg_ofs < 2**POS_W - 1.
module prep_timer
    import scan_pkg::*;
#(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase_i,
    input  logic             enter_bt_i,
    input  logic             rise_i,
    input  logic [POS_W-1:0] spr_ofs_i,
    input  logic [POS_W-1:0] bg_ofs_i,
    output logic             spr_prep_o,
    output logic             bg_prep_o,
    output logic             spr_drop_o
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    logic [POS_W-1:0] pos_q;
    logic             blank;
    logic             spr_busy;

    assign blank    = (phase_i != PH_VS);
    assign spr_busy = blank && (pos_q >= spr_ofs_i) && (pos_q < bg_ofs_i);

    // Track the blanking position within the line.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pos_q <= '0;
        else if (enter_bt_i)                 pos_q <= '0;
        else if (blank && pos_q != POS_MAX)  pos_q <= pos_q + POS_W'(1);
    end

    // Flag a sprite preparation cut short by a sync edge.
    always_ff @(posedge clk) begin
        if (!rst_n) spr_drop_o <= 1'b0;
        else        spr_drop_o <= rise_i && spr_busy;
    end

    assign spr_prep_o = blank && (pos_q == spr_ofs_i);
    assign bg_prep_o  = blank && (pos_q == bg_ofs_i);
endmodule

// File: rtl/scanline_phase_seq.sv
// Top of the externally synced scanline sequencer.
// Ties the sync edge detector, the phase engine and the preparation timer.
// Assumes one clock per pixel and a sync input already in the clk domain.
module scanline_phase_seq
    import scan_pkg::*;
#(
    parameter int LEN_W    = 6,
    parameter int CHAR_PIX = 8,
    parameter int POS_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [LEN_W-1:0] len_bt_i,
    input  logic [LEN_W-1:0] len_sw_i,
    input  logic [LEN_W-1:0] len_li_i,
    input  logic [LEN_W-1:0] len_vs_i,
    input  logic [POS_W-1:0] spr_ofs_i,
    input  logic [POS_W-1:0] bg_ofs_i,
    output logic [1:0]       phase_o,
    output logic             active_o,
    output logic             line_irq_o,
    output logic             spr_prep_o,
    output logic             bg_prep_o,
    output logic             spr_drop_o
);
    logic                         rise;
    logic                         enter_bt;
    phase_t                       phase;
    logic [NUM_PH-1:0][LEN_W-1:0] len_pk;

    assign len_pk = {len_vs_i, len_li_i, len_sw_i, len_bt_i};

    sync_edge_det u_edge (
        .clk     (clk),
        .sync_in (sync_in),
        .rise_o  (rise)
    );

    phase_engine #(.LEN_W(LEN_W), .CHAR_PIX(CHAR_PIX)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .len_pk     (len_pk),
        .phase_o    (phase),
        .enter_bt_o (enter_bt),
        .irq_o      (line_irq_o)
    );

    prep_timer #(.POS_W(POS_W)) u_prep (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .enter_bt_i (enter_bt),
        .rise_i     (rise),
        .spr_ofs_i  (spr_ofs_i),
        .bg_ofs_i   (bg_ofs_i),
        .spr_prep_o (spr_prep_o),
        .bg_prep_o  (bg_prep_o),
        .spr_drop_o (spr_drop_o)
    );

    assign phase_o  = phase;
    assign active_o = (phase == PH_VS);
endmodule

// File: rtl/scan_seq_chk.sv
// Port-level temporal checks for scanline_phase_seq, attached by bind.
module scan_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_in,
    input logic [1:0] phase_o,
    input logic       active_o,
    input logic       line_irq_o,
    input logic       spr_prep_o,
    input logic       bg_prep_o,
    input logic       spr_drop_o
);
    // R1
    ph_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != $past(phase_o)) |-> (phase_o == $past(phase_o) + 2'd1 || phase_o == 2'd0));

    // R3
    sw_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_in) && phase_o == 2'd1) |=> (phase_o == 2'd2));

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_in) && phase_o != 2'd1) |=> (phase_o == 2'd0 && line_irq_o));

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq_o |=> !line_irq_o);

    // R7
    irq_in_bt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq_o |-> (phase_o == 2'd0));

    // R10
    active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> ($past(phase_o) == 2'd2));

    // R8
    prep_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_prep_o || bg_prep_o) |-> !active_o);

    // R9
    drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spr_drop_o |=> !spr_drop_o);
endmodule

bind scanline_phase_seq scan_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_in    (sync_in),
    .phase_o    (phase_o),
    .active_o   (active_o),
    .line_irq_o (line_irq_o),
    .spr_prep_o (spr_prep_o),
    .bg_prep_o  (bg_prep_o),
    .spr_drop_o (spr_drop_o)
);

// File: tb/tb_scanline_phase_seq.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, t counts clocks since reset release.
module tb_scanline_phase_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0;
    logic [5:0] len_bt, len_sw, len_li, len_vs;
    logic [9:0] spr_ofs, bg_ofs;
    logic [1:0] phase;
    logic       active, irq, spr_prep, bg_prep, spr_drop;
    int         checks = 0;
    int         fails = 0;
    int         tcur = 0;
    bit         done = 1'b0;

    scanline_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .len_bt_i(len_bt), .len_sw_i(len_sw), .len_li_i(len_li), .len_vs_i(len_vs),
        .spr_ofs_i(spr_ofs), .bg_ofs_i(bg_ofs),
        .phase_o(phase), .active_o(active), .line_irq_o(irq),
        .spr_prep_o(spr_prep), .bg_prep_o(bg_prep), .spr_drop_o(spr_drop)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", req, tcur, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #5; tcur++;
        end
    endtask

    task automatic go(input int t);
        step(t - tcur);
    endtask

    // Reset with default setup; ends with t=0 state visible.
    task automatic do_reset(input int bt, input int sw, input int bg);
        @(negedge clk);
        rst_n = 1'b0; sync_in = 1'b0;
        len_bt = 6'(bt); len_sw = 6'(sw); len_li = 6'd1; len_vs = 6'd4;
        spr_ofs = 10'd4; bg_ofs = 10'(bg);
        repeat (3) @(posedge clk);
        #5; tcur = 0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic pulse();
        @(negedge clk); sync_in = 1'b1;
        step(1);
        @(negedge clk); sync_in = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(2, 3, 20);
        chk("R11 phase", phase, 0); chk("R11 irq", irq, 0);
        chk("R11 active", active, 0); chk("R11 drop", spr_drop, 0);
    endtask

    task automatic t_freerun();
        do_reset(2, 3, 20);
        go(3);  chk("R8 spr early", spr_prep, 0);
        go(4);  chk("R8 spr at ofs", spr_prep, 1);
        go(5);  chk("R8 spr once", spr_prep, 0);
        go(15); chk("R1 BT end", phase, 0);
        go(16); chk("R1 SW start", phase, 1);
        go(20); chk("R8 bg at ofs", bg_prep, 1);
        go(39); chk("R2 SW end", phase, 1);
        go(40); chk("R2 timeout to LI", phase, 2);
        go(47); chk("R1 LI end", phase, 2); chk("R10 inactive", active, 0);
        go(48); chk("R1 VS", phase, 3); chk("R10 active", active, 1);
        go(79); chk("R1 VS end", phase, 3); chk("R7 no irq", irq, 0);
        go(80); chk("R1 wrap", phase, 0); chk("R7 irq wrap", irq, 1);
        go(81); chk("R7 irq single", irq, 0);
        go(84); chk("R8 spr next line", spr_prep, 1);
    endtask

    task automatic t_sync_sw();
        do_reset(2, 3, 20);
        go(25); pulse();
        chk("R3 SW to LI", phase, 2); chk("R9 no drop after bg", spr_drop, 0);
        chk("R3 no irq", irq, 0);
        go(33); chk("R3 LI full", phase, 2);
        go(34); chk("R3 then VS", phase, 3);
    endtask

    task automatic t_sync_vs();
        do_reset(2, 3, 20);
        go(60); pulse();
        chk("R4 VS restart", phase, 0); chk("R7 irq restart", irq, 1);
        chk("R10 inactive", active, 0);
        go(65); chk("R4 pos cleared", spr_prep, 1);
        go(76); chk("R4 BT length", phase, 0);
        go(77); chk("R4 then SW", phase, 1);
    endtask

    task automatic t_drop_bt();
        do_reset(2, 3, 20);
        go(10); pulse();
        chk("R4 BT restart", phase, 0); chk("R9 drop", spr_drop, 1);
        go(12); chk("R9 drop single", spr_drop, 0);
        go(31); chk("R9 bg new line", bg_prep, 1);
    endtask

    task automatic t_drop_sw();
        do_reset(2, 3, 30);
        go(25); pulse();
        chk("R3 SW to LI", phase, 2); chk("R9 drop in SW", spr_drop, 1);
        go(29); chk("R9 bg not yet", bg_prep, 0);
        go(30); chk("R9 bg kept", bg_prep, 1); chk("R9 in LI", phase, 2);
    endtask

    task automatic t_nodrop_early();
        do_reset(2, 3, 20);
        go(2); pulse();
        chk("R9 no drop early", spr_drop, 0); chk("R4 restart", phase, 0);
        go(7); chk("R8 spr after restart", spr_prep, 1);
    endtask

    task automatic t_held();
        do_reset(2, 3, 20);
        go(50);
        @(negedge clk); sync_in = 1'b1;
        step(1); chk("R5 restart", phase, 0);
        go(66); chk("R5 held BT", phase, 0);
        go(67); chk("R5 held no restart", phase, 1);
        @(negedge clk); sync_in = 1'b0;
        go(68); chk("R5 after release", phase, 1);
    endtask

    task automatic t_prio();
        do_reset(2, 3, 20);
        go(15); pulse();
        chk("R6 sync wins", phase, 0); chk("R6 irq", irq, 1);
        go(31); chk("R6 BT full", phase, 0);
        go(32); chk("R6 then SW", phase, 1);
    endtask

    task automatic t_zero();
        do_reset(0, 0, 20);
        go(7);  chk("R1 zero BT", phase, 0);
        go(8);  chk("R1 zero BT one unit", phase, 1);
        go(15); chk("R1 zero SW", phase, 1);
        go(16); chk("R1 zero SW one unit", phase, 2);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_freerun();
        t_sync_sw();
        t_sync_vs();
        t_drop_bt();
        t_drop_sw();
        t_nodrop_early();
        t_held();
        t_prio();
        t_zero();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule